// File: doc/BRIEF.md
# Nibble Bus Peripheral Endpoint

This block is the device side of a shared parallel bus that extends the I/O port of a network node. The node owns a direction line (`rwIn`) and a strobe line (`csIn`). Each endpoint drives a handshake line (`hsOut`) back to the node. Data moves four bits at a time: on `nodeData` from the node to the device, and on `devData` from the device to the node. A falling edge on the direction line begins a packet, and every endpoint on the bus sees it at once. All endpoints assemble the first byte, which is an address. Only the endpoint whose identity matches it goes on to take in the length, the body and the checksum. The others drop out until the next packet begins.

After a packet that passes its checksum, the endpoint keeps the body in a small receive buffer and pulses a completion flag. When the node then raises the direction line, the endpoint returns a response packet. That packet holds its own address, a length, the body taken from a transmit buffer that the local application fills, and a checksum. The application side sees only the two packet buffers, the received length, the completion pulse and an error flag.

Top module: `nibble_bus_endpoint`

## Requirements
- R1: After reset, `hsOut`, `devDataEn`, `rxDone` and `pktErr` are 0 and `devData` is 0.
- R2: A falling edge of `rwIn` starts a packet. While `rwIn` is low, a nibble is taken from `nodeData` on each rising edge of `csIn`, high nibble of each byte first. `hsOut` toggles exactly once for each nibble accepted after the address byte. The two address nibbles are not acknowledged.
- R3: If the address byte differs from `devId`, the endpoint ignores the rest of the packet: `hsOut` does not toggle, `rxDone` does not pulse and `pktErr` stays 0 until the next packet.
- R4: The address byte is compared over all eight bits: location in bits 7:6, device type in bits 5:2 and instance in bits 1:0. A difference in any one field is a mismatch.
- R5: The byte after the address is the body length, from 0 to MAX_BODY (32). A larger value sets `pktErr` and drops the packet. A length of 0 is followed directly by the checksum byte.
- R6: The last byte is a checksum equal to the modulo-256 sum of the address, length and body bytes. On a match, `rxDone` pulses for one cycle, `rxLen` holds the length, and body byte i is read on `rxRdData` when `rxRdAddr` = i.
- R7: On a checksum mismatch, `pktErr` is set and `rxDone` does not pulse. `pktErr` holds until the next falling edge of `rwIn` clears it.
- R8: After a good packet, a rising edge of `rwIn` starts the response. `devDataEn` goes to 1 and `devData` carries, high nibble first, `devId`, then `txLen`, then `txLen` transmit-buffer bytes, then their modulo-256 sum. Each rising edge of `csIn` moves to the next nibble and toggles `hsOut`. After the last nibble `devDataEn` returns to 0.
- R9: In any state other than idle, if TIMEOUT_CYC cycles pass with no strobe or direction edge, the endpoint returns to idle. A later rising edge of `rwIn` then produces no response.
- R10: A falling edge of `rwIn` in any state abandons the current transfer and starts reception of a new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| devId | input | 8 | This endpoint's bus address (location, type, instance) |
| rwIn | input | 1 | Direction line from the node: low means the node sends, high means the node reads |
| csIn | input | 1 | Strobe from the node; the rising edge marks a nibble |
| nodeData | input | 4 | Nibble lines from the node to the device |
| hsOut | output | 1 | Handshake; toggles once for each acknowledged nibble |
| devData | output | 4 | Nibble lines from the device to the node |
| devDataEn | output | 1 | High while the endpoint drives `devData` |
| rxDone | output | 1 | One-cycle pulse when a valid packet addressed to this endpoint is complete |
| rxLen | output | 6 | Body length of the latest packet |
| rxRdAddr | input | 5 | Read index into the receive buffer |
| rxRdData | output | 8 | Receive buffer byte at `rxRdAddr` |
| pktErr | output | 1 | Set by a bad length or a bad checksum; cleared when a packet starts |
| txWrEn | input | 1 | Write enable for the transmit buffer |
| txWrAddr | input | 5 | Transmit buffer write index |
| txWrData | input | 8 | Transmit buffer write data |
| txLen | input | 6 | Response body length, latched when the response starts |

## Verification
The bench sends packets that differ from the endpoint's address in only one field each: location, type or instance. A design that compared only part of the byte would accept one of them and toggle the handshake. It also sends packets with a zero body, a 32-byte body, a length of 33 and a corrupted checksum. These cases catch an off-by-one in the byte counter, a missed length check, or a design that accepts bad data. The response is read back nibble by nibble and compared with a checksum the bench computes itself. An endpoint that ordered the nibbles wrongly, skipped a byte or summed the wrong bytes would fail there. Two further tests check the recovery paths. In one, the endpoint is left waiting past the timeout and the response must not appear. In the other, a new packet start interrupts a half-received packet, and the new packet must still be accepted.

// File: rtl/nbe_pkg.sv
package nbe_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LEN,
    ST_BODY,
    ST_CSUM,
    ST_WAIT,
    ST_TXADDR,
    ST_TXLEN,
    ST_TXBODY,
    ST_TXCSUM,
    ST_SKIP
  } nbeState_t;

  typedef enum logic [1:0] {
    TX_ID,
    TX_LEN,
    TX_BODY,
    TX_SUM
  } txSel_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic sumClr;
    logic sumAddRx;
    logic sumAddTx;
    logic latchHi;
    logic wrBody;
    logic ackNib;
    logic latchRxLen;
    logic latchTxLen;
  } nbeStrobe_t;

endpackage

// File: rtl/nbe_datapath.sv
module nbe_datapath
  import nbe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_BODY    = 32,
  parameter int LEN_W       = $clog2(MAX_BODY + 1),
  parameter int IDX_W       = $clog2(MAX_BODY)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rwIn,
  input  logic             csIn,
  input  logic [3:0]       nodeData,
  input  logic [7:0]       devId,
  input  nbeStrobe_t       strobe,
  input  txSel_t           txSel,
  input  logic             txLo,
  input  logic [IDX_W-1:0] bodyIdx,
  input  logic [LEN_W-1:0] txLen,
  input  logic             txWrEn,
  input  logic [IDX_W-1:0] txWrAddr,
  input  logic [7:0]       txWrData,
  input  logic [IDX_W-1:0] rxRdAddr,
  output logic             rwFall,
  output logic             rwRise,
  output logic             csRise,
  output logic             rwHigh,
  output logic [7:0]       rxByte,
  output logic             sumMatch,
  output logic [LEN_W-1:0] txLenQ,
  output logic [LEN_W-1:0] rxLenQ,
  output logic [7:0]       rxRdData,
  output logic [3:0]       devNib,
  output logic             hsOut
);

  localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_BODY);

  logic [SYNC_STAGES-1:0]      rwSh;
  logic [SYNC_STAGES-1:0]      csSh;
  logic [SYNC_STAGES-1:0][3:0] ndSh;
  logic                        rwPrev;
  logic                        csPrev;
  logic                        rwSync;
  logic                        csSync;
  logic [3:0]                  ndSync;
  logic [3:0]                  hiNib;
  logic [7:0]                  sumQ;
  logic [7:0]                  txByte;
  logic [7:0]                  rxBuf [MAX_BODY];
  logic [7:0]                  txBuf [MAX_BODY];

  assign rwSync = rwSh[SYNC_STAGES-1];
  assign csSync = csSh[SYNC_STAGES-1];
  assign ndSync = ndSh[SYNC_STAGES-1];

  // Synchronizer chains for the asynchronous bus lines
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rwSh   <= '1;
      csSh   <= '0;
      ndSh   <= '0;
      rwPrev <= 1'b1;
      csPrev <= 1'b0;
    end else begin
      rwSh[0] <= rwIn;
      csSh[0] <= csIn;
      ndSh[0] <= nodeData;
      for (int k = 1; k < SYNC_STAGES; k++) begin
        rwSh[k] <= rwSh[k-1];
        csSh[k] <= csSh[k-1];
        ndSh[k] <= ndSh[k-1];
      end
      rwPrev <= rwSync;
      csPrev <= csSync;
    end
  end

  assign rwFall = rwPrev & ~rwSync;
  assign rwRise = ~rwPrev & rwSync;
  assign csRise = ~csPrev & csSync;
  assign rwHigh = rwSync;

  assign rxByte   = {hiNib, ndSync};
  assign sumMatch = (sumQ == rxByte);

  // Outgoing byte selection
  always_comb begin
    unique case (txSel)
      TX_ID:   txByte = devId;
      TX_LEN:  txByte = 8'(txLenQ);
      TX_BODY: txByte = txBuf[bodyIdx];
      default: txByte = sumQ;
    endcase
  end

  assign devNib   = txLo ? txByte[3:0] : txByte[7:4];
  assign rxRdData = rxBuf[rxRdAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiNib  <= '0;
      sumQ   <= '0;
      hsOut  <= 1'b0;
      rxLenQ <= '0;
      txLenQ <= '0;
    end else begin
      if (strobe.latchHi)  hiNib <= ndSync;
      if (strobe.sumClr)        sumQ <= '0;
      else if (strobe.sumAddRx) sumQ <= sumQ + rxByte;
      else if (strobe.sumAddTx) sumQ <= sumQ + txByte;
      if (strobe.ackNib)   hsOut <= ~hsOut;
      if (strobe.latchRxLen) rxLenQ <= rxByte[LEN_W-1:0];
      if (strobe.latchTxLen) txLenQ <= (txLen > LEN_LIMIT) ? LEN_LIMIT : txLen;
    end
  end

  // Packet buffers (no reset: contents qualified by lengths)
  always_ff @(posedge clk) begin
    if (strobe.wrBody) rxBuf[bodyIdx] <= rxByte;
    if (txWrEn)        txBuf[txWrAddr] <= txWrData;
  end

endmodule

// File: rtl/nbe_ctrl.sv
module nbe_ctrl
  import nbe_pkg::*;
#(
  parameter int MAX_BODY    = 32,
  parameter int TIMEOUT_CYC = 4096,
  parameter int LEN_W       = $clog2(MAX_BODY + 1),
  parameter int IDX_W       = $clog2(MAX_BODY),
  parameter int TO_W        = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rwFall,
  input  logic             rwRise,
  input  logic             csRise,
  input  logic             rwHigh,
  input  logic [7:0]       rxByte,
  input  logic             sumMatch,
  input  logic [LEN_W-1:0] txLenQ,
  input  logic [7:0]       devId,
  output nbeStrobe_t       strobe,
  output txSel_t           txSel,
  output logic             txLo,
  output logic [IDX_W-1:0] bodyIdx,
  output logic             devDataEn,
  output logic             rxDone,
  output logic             pktErr
);

  localparam logic [7:0]      LEN_MAX_B = 8'(MAX_BODY);
  localparam logic [TO_W-1:0] TO_LAST   = TO_W'(TIMEOUT_CYC - 1);

  nbeState_t        state, stNext;
  logic             loPhase, loNext;
  logic [LEN_W-1:0] byteCnt, cntNext;
  logic [LEN_W-1:0] lenQ, lenNext;
  logic [LEN_W-1:0] cntInc;
  logic [TO_W-1:0]  toCnt;
  logic             doneNext, errNext;
  logic             toExpire;
  logic             rxNib, txNib;

  assign cntInc   = byteCnt + LEN_W'(1);
  assign toExpire = (state != ST_IDLE) && (toCnt == TO_LAST);
  assign rxNib    = csRise & ~rwHigh;
  assign txNib    = csRise & rwHigh;
  assign txLo     = loPhase;
  assign bodyIdx  = byteCnt[IDX_W-1:0];

  always_comb begin
    stNext   = state;
    loNext   = loPhase;
    cntNext  = byteCnt;
    lenNext  = lenQ;
    strobe   = '0;
    doneNext = 1'b0;
    errNext  = pktErr;
    if (rwFall) begin
      stNext        = ST_ADDR;
      loNext        = 1'b0;
      cntNext       = '0;
      strobe.sumClr = 1'b1;
      errNext       = 1'b0;
    end else if (toExpire) begin
      stNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR: if (rxNib) begin
          if (!loPhase) begin
            strobe.latchHi = 1'b1;
            loNext         = 1'b1;
          end else begin
            loNext = 1'b0;
            if (rxByte == devId) begin
              strobe.sumAddRx = 1'b1;
              stNext          = ST_LEN;
            end else begin
              stNext = ST_SKIP;
            end
          end
        end
        ST_LEN: if (rxNib) begin
          strobe.ackNib = 1'b1;
          if (!loPhase) begin
            strobe.latchHi = 1'b1;
            loNext         = 1'b1;
          end else begin
            loNext          = 1'b0;
            strobe.sumAddRx = 1'b1;
            if (rxByte > LEN_MAX_B) begin
              errNext = 1'b1;
              stNext  = ST_SKIP;
            end else begin
              lenNext           = rxByte[LEN_W-1:0];
              strobe.latchRxLen = 1'b1;
              cntNext           = '0;
              stNext            = (rxByte == 8'd0) ? ST_CSUM : ST_BODY;
            end
          end
        end
        ST_BODY: if (rxNib) begin
          strobe.ackNib = 1'b1;
          if (!loPhase) begin
            strobe.latchHi = 1'b1;
            loNext         = 1'b1;
          end else begin
            loNext          = 1'b0;
            strobe.sumAddRx = 1'b1;
            strobe.wrBody   = 1'b1;
            cntNext         = cntInc;
            if (cntInc == lenQ) stNext = ST_CSUM;
          end
        end
        ST_CSUM: if (rxNib) begin
          strobe.ackNib = 1'b1;
          if (!loPhase) begin
            strobe.latchHi = 1'b1;
            loNext         = 1'b1;
          end else begin
            loNext = 1'b0;
            if (sumMatch) begin
              doneNext = 1'b1;
              stNext   = ST_WAIT;
            end else begin
              errNext = 1'b1;
              stNext  = ST_SKIP;
            end
          end
        end
        ST_WAIT: if (rwRise) begin
          stNext            = ST_TXADDR;
          loNext            = 1'b0;
          cntNext           = '0;
          strobe.sumClr     = 1'b1;
          strobe.latchTxLen = 1'b1;
        end
        ST_TXADDR, ST_TXLEN, ST_TXBODY, ST_TXCSUM: if (txNib) begin
          strobe.ackNib = 1'b1;
          if (!loPhase) begin
            loNext = 1'b1;
          end else begin
            loNext          = 1'b0;
            strobe.sumAddTx = 1'b1;
            unique case (state)
              ST_TXADDR: stNext = ST_TXLEN;
              ST_TXLEN: begin
                cntNext = '0;
                stNext  = (txLenQ == '0) ? ST_TXCSUM : ST_TXBODY;
              end
              ST_TXBODY: begin
                cntNext = cntInc;
                if (cntInc == txLenQ) stNext = ST_TXCSUM;
              end
              default: stNext = ST_IDLE;
            endcase
          end
        end
        ST_SKIP: if (rwRise) stNext = ST_IDLE;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_TXLEN:  txSel = TX_LEN;
      ST_TXBODY: txSel = TX_BODY;
      ST_TXCSUM: txSel = TX_SUM;
      default:   txSel = TX_ID;
    endcase
  end

  assign devDataEn = (state == ST_TXADDR) || (state == ST_TXLEN) ||
                     (state == ST_TXBODY) || (state == ST_TXCSUM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      loPhase <= 1'b0;
      byteCnt <= '0;
      lenQ    <= '0;
      rxDone  <= 1'b0;
      pktErr  <= 1'b0;
      toCnt   <= '0;
    end else begin
      state   <= stNext;
      loPhase <= loNext;
      byteCnt <= cntNext;
      lenQ    <= lenNext;
      rxDone  <= doneNext;
      pktErr  <= errNext;
      if (state == ST_IDLE || csRise || rwFall || rwRise || toExpire) toCnt <= '0;
      else                                                         toCnt <= toCnt + TO_W'(1);
    end
  end

endmodule

// File: rtl/nibble_bus_endpoint.sv
module nibble_bus_endpoint
  import nbe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_BODY    = 32,
  parameter int TIMEOUT_CYC = 4096,
  parameter int LEN_W       = $clog2(MAX_BODY + 1),
  parameter int IDX_W       = $clog2(MAX_BODY)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       devId,
  input  logic             rwIn,
  input  logic             csIn,
  input  logic [3:0]       nodeData,
  output logic             hsOut,
  output logic [3:0]       devData,
  output logic             devDataEn,
  output logic             rxDone,
  output logic [LEN_W-1:0] rxLen,
  input  logic [IDX_W-1:0] rxRdAddr,
  output logic [7:0]       rxRdData,
  output logic             pktErr,
  input  logic             txWrEn,
  input  logic [IDX_W-1:0] txWrAddr,
  input  logic [7:0]       txWrData,
  input  logic [LEN_W-1:0] txLen
);

  nbeStrobe_t       strobe;
  txSel_t           txSel;
  logic             txLo;
  logic [IDX_W-1:0] bodyIdx;
  logic             rwFall, rwRise, csRise, rwHigh;
  logic [7:0]       rxByte;
  logic             sumMatch;
  logic [LEN_W-1:0] txLenQ;
  logic [3:0]       devNib;

  nbe_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .MAX_BODY   (MAX_BODY),
    .LEN_W      (LEN_W),
    .IDX_W      (IDX_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .rwIn    (rwIn),
    .csIn    (csIn),
    .nodeData(nodeData),
    .devId   (devId),
    .strobe  (strobe),
    .txSel   (txSel),
    .txLo    (txLo),
    .bodyIdx (bodyIdx),
    .txLen   (txLen),
    .txWrEn  (txWrEn),
    .txWrAddr(txWrAddr),
    .txWrData(txWrData),
    .rxRdAddr(rxRdAddr),
    .rwFall  (rwFall),
    .rwRise  (rwRise),
    .csRise  (csRise),
    .rwHigh  (rwHigh),
    .rxByte  (rxByte),
    .sumMatch(sumMatch),
    .txLenQ  (txLenQ),
    .rxLenQ  (rxLen),
    .rxRdData(rxRdData),
    .devNib  (devNib),
    .hsOut   (hsOut)
  );

  nbe_ctrl #(
    .MAX_BODY   (MAX_BODY),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .LEN_W      (LEN_W),
    .IDX_W      (IDX_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .rwFall   (rwFall),
    .rwRise   (rwRise),
    .csRise   (csRise),
    .rwHigh   (rwHigh),
    .rxByte   (rxByte),
    .sumMatch (sumMatch),
    .txLenQ   (txLenQ),
    .devId    (devId),
    .strobe   (strobe),
    .txSel    (txSel),
    .txLo     (txLo),
    .bodyIdx  (bodyIdx),
    .devDataEn(devDataEn),
    .rxDone   (rxDone),
    .pktErr   (pktErr)
  );

  assign devData = devDataEn ? devNib : 4'h0;

endmodule

// File: rtl/nbe_checker.sv
module nbe_checker #(
  parameter int MAX_BODY = 32,
  parameter int LEN_W    = $clog2(MAX_BODY + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             hsOut,
  input logic             csRise,
  input logic             rwFall,
  input logic             rwHigh,
  input logic             rxDone,
  input logic             pktErr,
  input logic             devDataEn,
  input logic [LEN_W-1:0] rxLen
);

  AST_HS_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (hsOut != $past(hsOut)) |-> $past(csRise)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone); // R6

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> (rxLen <= LEN_W'(MAX_BODY))); // R5

  AST_NO_DONE_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> !pktErr); // R7

  AST_START_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    rwFall |=> !pktErr); // R10

  AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    devDataEn |-> $past(rwHigh)); // R8

endmodule

bind nibble_bus_endpoint nbe_checker #(
  .MAX_BODY(MAX_BODY)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .hsOut    (hsOut),
  .csRise   (csRise),
  .rwFall   (rwFall),
  .rwHigh   (rwHigh),
  .rxDone   (rxDone),
  .pktErr   (pktErr),
  .devDataEn(devDataEn),
  .rxLen    (rxLen)
);

// File: tb/nibble_bus_endpoint_tb_top.sv
module nibble_bus_endpoint_tb_top;

  localparam int         MAXB   = 32;
  localparam int         TO_CYC = 200;
  localparam logic [7:0] MY_ID  = 8'h99; // location 2, type 6, instance 1

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rwIn = 1'b1;
  logic       csIn = 1'b0;
  logic [3:0] nodeData = 4'h0;
  logic       hsOut;
  logic [3:0] devData;
  logic       devDataEn;
  logic       rxDone;
  logic [5:0] rxLen;
  logic [4:0] rxRdAddr = '0;
  logic [7:0] rxRdData;
  logic       pktErr;
  logic       txWrEn = 1'b0;
  logic [4:0] txWrAddr = '0;
  logic [7:0] txWrData = '0;
  logic [5:0] txLen = '0;

  int total = 0;
  int bad = 0;
  int hsCnt = 0;
  int doneCnt = 0;
  logic hsPrev = 1'b0;
  logic [7:0] bodyBuf [MAXB + 1];

  always #10 clk = ~clk;

  nibble_bus_endpoint #(.TIMEOUT_CYC(TO_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .devId(MY_ID), .rwIn(rwIn), .csIn(csIn),
    .nodeData(nodeData), .hsOut(hsOut), .devData(devData), .devDataEn(devDataEn),
    .rxDone(rxDone), .rxLen(rxLen), .rxRdAddr(rxRdAddr), .rxRdData(rxRdData),
    .pktErr(pktErr), .txWrEn(txWrEn), .txWrAddr(txWrAddr), .txWrData(txWrData),
    .txLen(txLen)
  );

  always @(negedge clk) begin
    if (hsOut !== hsPrev) hsCnt++;
    hsPrev = hsOut;
    if (rxDone) doneCnt++;
  end

  // fields: addr, len, b0, b1, b2, corrupt, expDone, expErr
  localparam int NV = 7;
  localparam logic [42:0] VEC [NV] = '{
    {8'h99, 8'd3, 8'h11, 8'h22, 8'h33, 1'b0, 1'b1, 1'b0},
    {8'h99, 8'd1, 8'hA5, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0},
    {8'h98, 8'd2, 8'h01, 8'h02, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h59, 8'd2, 8'h01, 8'h02, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h99, 8'd2, 8'hFF, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b1},
    {8'h9D, 8'd1, 8'h44, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h99, 8'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendNib(input logic [3:0] n);
    nodeData = n;
    tick(3);
    csIn = 1'b1;
    tick(6);
    csIn = 1'b0;
    tick(3);
  endtask

  task automatic sendByte(input logic [7:0] b);
    sendNib(b[7:4]);
    sendNib(b[3:0]);
  endtask

  task automatic startPkt();
    rwIn = 1'b1;
    tick(4);
    rwIn = 1'b0;
    tick(5);
  endtask

  task automatic sendPkt(input logic [7:0] a, input logic [7:0] l, input int n, input bit corrupt);
    logic [7:0] s;
    s = a + l;
    startPkt();
    sendByte(a);
    sendByte(l);
    for (int i = 0; i < n; i++) begin
      sendByte(bodyBuf[i]);
      s = s + bodyBuf[i];
    end
    sendByte(corrupt ? s + 8'd1 : s);
    tick(4);
  endtask

  task automatic readNib(output logic [3:0] n);
    tick(2);
    n = devData;
    csIn = 1'b1;
    tick(6);
    csIn = 1'b0;
    tick(3);
  endtask

  task automatic checkBody(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      rxRdAddr = 5'(i);
      tick(1);
      chk(rxRdData == bodyBuf[i], req, rxRdData, bodyBuf[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int h0, d0, len;
    logic [7:0] s;
    logic [3:0] nb;
    logic [7:0] expB [6];
    tick(5);
    rstN = 1'b1;
    tick(2);
    // R1 reset state
    chk(hsOut == 1'b0 && devDataEn == 1'b0 && rxDone == 1'b0 && pktErr == 1'b0 && devData == 4'h0,
        "R1", {hsOut, devDataEn, rxDone, pktErr}, 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      len = int'(VEC[v][34:27]);
      bodyBuf[0] = VEC[v][26:19];
      bodyBuf[1] = VEC[v][18:11];
      bodyBuf[2] = VEC[v][10:3];
      h0 = hsCnt;
      d0 = doneCnt;
      sendPkt(VEC[v][42:35], VEC[v][34:27], len, VEC[v][2]);
      chk((doneCnt - d0) == int'(VEC[v][1]), "R6/R4 done pulse", doneCnt - d0, int'(VEC[v][1]));
      chk(pktErr == VEC[v][0], "R7 error flag", pktErr, VEC[v][0]);
      if (VEC[v][42:35] != MY_ID)
        chk(hsCnt == h0, "R3 no handshake on mismatch", hsCnt - h0, 0);
      else
        chk(hsCnt - h0 == 2 * (len + 2), "R2 handshake count", hsCnt - h0, 2 * (len + 2));
      if (VEC[v][1]) begin
        chk(rxLen == 6'(len), "R6 rxLen", rxLen, len);
        checkBody(len, "R6 body");
      end
    end

    // R10 error cleared by next start
    startPkt();
    chk(pktErr == 1'b0, "R10 error cleared at start", pktErr, 0);

    // R5 length above limit
    d0 = doneCnt;
    sendPkt(MY_ID, 8'd33, 0, 1'b0);
    chk(pktErr == 1'b1, "R5 oversize length error", pktErr, 1);
    chk(doneCnt == d0, "R5 oversize no done", doneCnt - d0, 0);

    // R5 maximum body
    for (int i = 0; i < MAXB; i++) bodyBuf[i] = 8'(i * 7 + 3);
    d0 = doneCnt;
    sendPkt(MY_ID, 8'd32, MAXB, 1'b0);
    chk(doneCnt - d0 == 1 && rxLen == 6'd32, "R5 max body accepted", rxLen, 32);
    checkBody(MAXB, "R5 max body content");

    // R8 response packet
    bodyBuf[0] = 8'hC3;
    bodyBuf[1] = 8'h5A;
    sendPkt(MY_ID, 8'd2, 2, 1'b0);
    for (int i = 0; i < 3; i++) begin
      txWrEn = 1'b1;
      txWrAddr = 5'(i);
      txWrData = 8'(i + 1);
      tick(1);
    end
    txWrEn = 1'b0;
    txLen = 6'd3;
    expB[0] = MY_ID;
    expB[1] = 8'd3;
    expB[2] = 8'd1;
    expB[3] = 8'd2;
    expB[4] = 8'd3;
    s = 8'h00;
    for (int i = 0; i < 5; i++) s = s + expB[i];
    expB[5] = s;
    h0 = hsCnt;
    rwIn = 1'b1;
    tick(6);
    chk(devDataEn == 1'b1, "R8 drive enabled", devDataEn, 1);
    for (int i = 0; i < 6; i++) begin
      readNib(nb);
      chk(nb == expB[i][7:4], "R8 high nibble", nb, expB[i][7:4]);
      readNib(nb);
      chk(nb == expB[i][3:0], "R8 low nibble", nb, expB[i][3:0]);
    end
    chk(hsCnt - h0 == 12, "R8 response handshakes", hsCnt - h0, 12);
    chk(devDataEn == 1'b0, "R8 drive released", devDataEn, 0);

    // R9 timeout while waiting for the read
    bodyBuf[0] = 8'h10;
    sendPkt(MY_ID, 8'd1, 1, 1'b0);
    tick(TO_CYC + 60);
    rwIn = 1'b1;
    tick(8);
    chk(devDataEn == 1'b0, "R9 no response after timeout", devDataEn, 0);

    // R10 restart mid-packet
    startPkt();
    sendByte(MY_ID);
    sendByte(8'd3);
    sendByte(8'h77);
    bodyBuf[0] = 8'h6E;
    bodyBuf[1] = 8'h01;
    d0 = doneCnt;
    sendPkt(MY_ID, 8'd2, 2, 1'b0);
    chk(doneCnt - d0 == 1 && rxLen == 6'd2, "R10 restart accepted", rxLen, 2);
    checkBody(2, "R10 restart body");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule